// File: doc/BRIEF.md
# Latch-up Guard Controller for One Supply Rail

This block is the digital side of a latch-up guard for a single supply rail. An external converter delivers load-current samples, each flagged by a valid strobe. Software programs the largest current the load normally draws. When a sample shows more than twice that figure, the block treats it as a parasitic latch firing. It then cuts the rail, closes a bypass switch that drains the leftover current away from the load, and keeps the rail off for a fixed number of millisecond ticks. After that it reconnects the load without any outside help.

Power comes back in two steps. The bypass switch opens first. One clock later the rail switch closes, so the two switches are never closed at the same time. The block also keeps a count of the trips it has taken. The count stops at its maximum value, and a clear input resets it. Samples that arrive while the rail is off are ignored. They can neither start a second trip nor lengthen the off interval.

Top module: `lu_guard`

## Requirements
- R1: During and right after reset, load_conn is 1, shunt_on is 0, trip_pulse is 0 and evt_cnt is 0.
- R2: While load_conn is 1, the block takes a sample at a clock edge when sense_vld is 1 and the unsigned 13-bit sense_val is strictly greater than nom_lim shifted left by one bit. In the next cycle load_conn is 0, shunt_on is 1 and trip_pulse is 1. A sample equal to twice nom_lim does not trip the block, and neither does any value when sense_vld is 0.
- R3: shunt_on stays high until the edge that samples the OFF_TICKS-th ms_tick seen while shunt_on is high, counting a tick present in the trip_pulse cycle. It is low in the cycle after that edge.
- R4: When shunt_on falls, load_conn stays 0 for exactly that one cycle and is 1 in the cycle after.
- R5: load_conn and shunt_on are never both 1.
- R6: While the rail is off (shunt_on is 1, or the one-cycle gap that follows), over-limit samples are ignored. They raise no trip_pulse, leave evt_cnt unchanged and do not alter the off interval. trip_pulse is high for one cycle per trip.
- R7: evt_cnt rises by one with each trip_pulse and holds at 255 once it reaches 255.
- R8: evt_clr sampled high at an edge sets evt_cnt to 0 after that edge. If a trip is accepted at the same edge, evt_cnt becomes 1 instead.
- R9: Once load_conn is back at 1, the next over-limit sample trips the block again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sense_vld | input | 1 | Marks sense_val as a fresh sample |
| sense_val | input | 13 | Load-current sample, unsigned |
| nom_lim | input | 12 | Nominal maximum regular current of the load |
| ms_tick | input | 1 | One-cycle timebase pulse, nominally every 1 ms |
| evt_clr | input | 1 | Clears the trip counter |
| load_conn | output | 1 | 1 = rail switch closed, load powered |
| shunt_on | output | 1 | 1 = bypass switch closed, residual current drained |
| trip_pulse | output | 1 | One-cycle pulse for each accepted trip |
| evt_cnt | output | 8 | Saturating count of trips |

## Verification
A wrong state in the sequencer appears on the switch outputs in the very next cycle. It would show as both switches closed, as a missing gap cycle, or as an off interval one tick too long or too short. A timer that fails to clear at the trip changes how long the next off interval lasts, so the error only shows at the end of the following trip. A counter fault shows on evt_cnt in the cycle of the trip or clear that caused it, or it stays hidden until the count runs into its saturation limit. Comparator faults are found with samples placed exactly at twice the limit and one step above it.

// File: rtl/lu_guard_pkg.sv
package lu_guard_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_ISOL = 2'd1,
    ST_GAP  = 2'd2
  } lu_state_e;

  // True when a sample exceeds twice the nominal limit.
  function automatic logic exceeds_twice(input logic [31:0] smp,
                                         input logic [31:0] nom);
    logic [31:0] lvl;
    lvl = nom << 1;
    return smp > lvl;
  endfunction

  // Increment that stops at maxv.
  function automatic logic [31:0] sat_step(input logic [31:0] v,
                                           input logic [31:0] maxv);
    return (v >= maxv) ? maxv : v + 32'd1;
  endfunction

endpackage

// File: rtl/lu_cmp.sv
module lu_cmp #(
  parameter int NOM_W = 12
) (
  input  logic             smp_vld,
  input  logic [NOM_W:0]   smp_val,
  input  logic [NOM_W-1:0] nom_lim,
  output logic             over
);
  import lu_guard_pkg::*;

  assign over = smp_vld & exceeds_twice(32'(smp_val), 32'(nom_lim));

endmodule

// File: rtl/lu_timer.sv
module lu_timer #(
  parameter int OFF_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic tick,
  output logic done
);
  localparam int TMR_W = $clog2(OFF_TICKS + 1);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(OFF_TICKS - 1);

  logic [TMR_W-1:0] tcnt;

  assign done = active & tick & (tcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (start) begin
      tcnt <= '0;
    end else if (active && tick && !done) begin
      tcnt <= tcnt + 1'b1;
    end
  end

endmodule

// File: rtl/lu_seq.sv
module lu_seq (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    over,
  input  logic                    off_done,
  output lu_guard_pkg::lu_state_e state,
  output logic                    trip_now,
  output logic                    trip_pulse
);
  import lu_guard_pkg::*;

  lu_state_e nxt;

  assign trip_now = (state == ST_RUN) & over;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:  if (trip_now) nxt = ST_ISOL;
      ST_ISOL: if (off_done) nxt = ST_GAP;
      ST_GAP:  nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      trip_pulse <= 1'b0;
    end else begin
      state      <= nxt;
      trip_pulse <= trip_now;
    end
  end

endmodule

// File: rtl/lu_evcnt.sv
module lu_evcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  import lu_guard_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] nxt;

  always_comb begin
    if (clr)      nxt = inc ? CNT_W'(1) : '0;
    else if (inc) nxt = CNT_W'(sat_step(32'(count), 32'(CNT_MAX)));
    else          nxt = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

endmodule

// File: rtl/lu_guard.sv
module lu_guard #(
  parameter int NOM_W     = 12,
  parameter int OFF_TICKS = 100,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sense_vld,
  input  logic [NOM_W:0]   sense_val,
  input  logic [NOM_W-1:0] nom_lim,
  input  logic             ms_tick,
  input  logic             evt_clr,
  output logic             load_conn,
  output logic             shunt_on,
  output logic             trip_pulse,
  output logic [CNT_W-1:0] evt_cnt
);
  import lu_guard_pkg::*;

  logic      over_hit;
  logic      trip_now;
  logic      off_done;
  lu_state_e state;

  lu_cmp #(.NOM_W(NOM_W)) u_cmp (
    .smp_vld (sense_vld),
    .smp_val (sense_val),
    .nom_lim (nom_lim),
    .over    (over_hit)
  );

  lu_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .over       (over_hit),
    .off_done   (off_done),
    .state      (state),
    .trip_now   (trip_now),
    .trip_pulse (trip_pulse)
  );

  lu_timer #(.OFF_TICKS(OFF_TICKS)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (trip_now),
    .active (state == ST_ISOL),
    .tick   (ms_tick),
    .done   (off_done)
  );

  lu_evcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (trip_now),
    .clr   (evt_clr),
    .count (evt_cnt)
  );

  assign load_conn = (state == ST_RUN);
  assign shunt_on  = (state == ST_ISOL);

endmodule

// File: rtl/lu_guard_chk.sv
module lu_guard_chk #(
  parameter int OFF_TICKS = 100,
  parameter int CNT_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ms_tick,
  input logic             evt_clr,
  input logic             load_conn,
  input logic             shunt_on,
  input logic             trip_pulse,
  input logic [CNT_W-1:0] evt_cnt,
  input logic             off_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  int unsigned win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  win_cnt <= 0;
    else if (trip_pulse)         win_cnt <= ms_tick ? 1 : 0;
    else if (shunt_on && ms_tick) win_cnt <= win_cnt + 1;
  end

  assert_no_crowbar_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_conn && shunt_on));

  assert_trip_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse |-> (shunt_on && !load_conn));

  assert_trip_from_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse |-> $past(load_conn));

  assert_trip_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse |=> !trip_pulse);

  assert_off_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shunt_on) |-> (win_cnt == OFF_TICKS));

  assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    off_done |=> !shunt_on);

  assert_gap_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shunt_on) |-> !load_conn);

  assert_gap_then_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shunt_on) |=> load_conn);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_pulse && !$past(evt_clr) && $past(evt_cnt) != CNT_MAX)
      |-> evt_cnt == $past(evt_cnt) + 1'b1);

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_pulse && !$past(evt_clr)) |-> $stable(evt_cnt));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_clr) |-> evt_cnt == (trip_pulse ? CNT_W'(1) : CNT_W'(0)));

endmodule

bind lu_guard lu_guard_chk #(.OFF_TICKS(OFF_TICKS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ms_tick    (ms_tick),
  .evt_clr    (evt_clr),
  .load_conn  (load_conn),
  .shunt_on   (shunt_on),
  .trip_pulse (trip_pulse),
  .evt_cnt    (evt_cnt),
  .off_done   (off_done)
);

// File: tb/tb_lu_guard.sv
module tb_lu_guard;
  localparam int OFF = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        sense_vld;
  logic [12:0] sense_val;
  logic [11:0] nom_lim;
  logic        ms_tick;
  logic        evt_clr;
  logic        load_conn, shunt_on, trip_pulse;
  logic [7:0]  evt_cnt;

  lu_guard #(.NOM_W(12), .OFF_TICKS(OFF), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .sense_vld(sense_vld), .sense_val(sense_val),
    .nom_lim(nom_lim), .ms_tick(ms_tick), .evt_clr(evt_clr),
    .load_conn(load_conn), .shunt_on(shunt_on), .trip_pulse(trip_pulse),
    .evt_cnt(evt_cnt)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  bit m_conn, m_shunt, m_gap, m_trip;
  int m_ticks, m_cnt;
  bit prev_shunt, expect_reconnect;

  function automatic bit over_f(bit v, int d, int n);
    return v && (d > 2 * n);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit inc;
    inc = m_conn && over_f(sense_vld, int'(sense_val), int'(nom_lim));
    if (evt_clr)                  m_cnt = inc ? 1 : 0;
    else if (inc && m_cnt < 255)  m_cnt = m_cnt + 1;
    m_trip = 0;
    if (m_gap) begin
      m_gap = 0; m_conn = 1;
    end else if (m_shunt) begin
      if (ms_tick) m_ticks++;
      if (m_ticks == OFF) begin m_shunt = 0; m_gap = 1; end
    end else if (inc) begin
      m_trip = 1; m_conn = 0; m_shunt = 1; m_ticks = 0;
    end
    @(posedge clk); #5;
    chk(tag, "load_conn", int'(load_conn), int'(m_conn));
    chk(tag, "shunt_on", int'(shunt_on), int'(m_shunt));
    chk(tag, "trip_pulse", int'(trip_pulse), int'(m_trip));
    chk(tag, "evt_cnt", int'(evt_cnt), m_cnt);
    if (load_conn && shunt_on) chk("R5", "both switches closed", 1, 0);
    if (expect_reconnect) chk("R4", "reconnect after gap", int'(load_conn), 1);
    expect_reconnect = 0;
    if (prev_shunt && !shunt_on) begin
      chk("R4", "rail still open at shunt release", int'(load_conn), 0);
      expect_reconnect = 1;
    end
    prev_shunt = shunt_on;
  endtask

  task automatic set_in(bit v, int d, bit t, bit c);
    sense_vld = v; sense_val = 13'(d); ms_tick = t; evt_clr = c;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_in(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "reset load_conn", int'(load_conn), 1);
    chk("R1", "reset shunt_on", int'(shunt_on), 0);
    chk("R1", "reset trip_pulse", int'(trip_pulse), 0);
    chk("R1", "reset evt_cnt", int'(evt_cnt), 0);
    rst_n = 1'b1;
    m_conn = 1; m_shunt = 0; m_gap = 0; m_trip = 0; m_ticks = 0; m_cnt = 0;
    prev_shunt = 0; expect_reconnect = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL R3 watchdog expired: got 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int tripped_at;
    seed = 32'd20240607;
    void'($urandom(seed));
    nom_lim = 12'd100;
    do_reset();
    step("R1");

    // R2 threshold corners
    set_in(1, 200, 0, 0); step("R2");
    set_in(0, 8191, 0, 0); step("R2");
    set_in(1, 201, 0, 0); step("R2");
    chk("R2", "trip on 2x+1", int'(trip_pulse), 1);

    // R6/R3: keep hammering over-limit samples while off, ticks every other cycle
    tripped_at = 0;
    for (int i = 0; i < 30; i++) begin
      set_in(1, 8191, (i % 2) == 0, 0);
      step(m_conn ? "R9" : "R6");
      if (trip_pulse) tripped_at++;
    end
    chk("R9", "retrip after reconnect", int'(tripped_at >= 1), 1);

    // R8: plain clear, then clear with simultaneous trip
    set_in(0, 0, 1, 0);
    for (int i = 0; i < 12; i++) step("R3");
    set_in(0, 0, 0, 1); step("R8");
    chk("R8", "cleared count", int'(evt_cnt), 0);
    set_in(1, 4000, 0, 1); step("R8");
    chk("R8", "clear with trip", int'(evt_cnt), 1);

    // R7: saturation
    for (int i = 0; i < 2200; i++) begin
      set_in(1, 8191, 1, 0);
      step("R7");
    end
    chk("R7", "saturated count", int'(evt_cnt), 255);

    // Constrained random around the threshold
    set_in(0, 0, 0, 1); step("R8");
    for (int i = 0; i < 6000; i++) begin
      int n, d;
      if ((i % 500) == 0) nom_lim = 12'($urandom_range(0, 4095));
      n = int'(nom_lim);
      d = 2 * n + int'($urandom_range(0, 6)) - 3;
      if (d < 0) d = 0;
      if (d > 8191) d = 8191;
      set_in($urandom_range(0, 1) == 1, d, $urandom_range(0, 2) == 0,
             $urandom_range(0, 63) == 0);
      step("R2");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule